// File: doc/BRIEF.md
# Execute-Stage Control Decoder for a Reduced RISC-V Core

This purely combinational unit sits in the execute stage of a three-stage RISC-V pipeline (fetch, execute, writeback). It takes the opcode, funct3, funct7 and 12-bit immediate/CSR fields of the instruction being executed. From these it produces the ALU operation and operand select, the writeback source, the register-file and display write enables, and the next-PC source.

Conditional branches are resolved by the ALU itself. The decoder selects subtract, signed compare or unsigned compare, and then tests the result that comes back. The CSR swap instruction serves as a simple I/O port: one address drives a display register and another returns the switch inputs.

Any redirect (a taken branch, jal or jalr) raises a request to squash the instruction fetched behind it. A registered stall input marks the current instruction as squashed, and the decoder then suppresses all of its side effects.

Top module: `rv_ctrl_unit`

## Requirements
- R1: For opcode 0x33, alu_src_o=0, wb_sel_o=2'b10 and reg_we_o=1. alu_op_o follows funct3 and funct7:
  - funct3 000: add 0011 (funct7 0x00), sub 0100 (0x20), mul 0101 (0x01).
  - funct3 001: sll 1000 (0x00), mulh 0110 (0x01).
  - funct3 010: slt 1100.
  - funct3 011: sltu 1101 (0x00), mulhu 0111 (0x01).
  - funct3 100: xor 0010.
  - funct3 101: srl 1001 (0x00), sra 1010 (0x20).
  - funct3 110: or 0001.
  - funct3 111: and 0000.
- R2: For opcode 0x13, alu_src_o=1, wb_sel_o=2'b10 and reg_we_o=1. alu_op_o uses the same funct3 map as R1 with funct7 treated as 0x00 (so funct3 000 is always add), except that funct3 101 with funct7 0x20 gives sra 1010.
- R3: For opcode 0x37, wb_sel_o=2'b01, reg_we_o=1 and gpio_we_o=0.
- R4: For opcode 0x73 with funct3 001 and CSR field 0xF02, gpio_we_o=1 and reg_we_o=0.
- R5: For opcode 0x73 with funct3 001 and CSR field 0xF00, wb_sel_o=2'b00, reg_we_o=1 and gpio_we_o=0.
- R6: For opcode 0x63, alu_src_o=0 and reg_we_o=0. alu_op_o is:
  - sub 0100 for funct3 000 and 001;
  - slt 1100 for funct3 100 and 101;
  - sltu 1101 for funct3 110 and 111.
- R7: A branch is taken when:
  - beq (000): alu_zero_i=1.
  - bne (001): alu_zero_i=0.
  - blt/bltu (100/110): alu_res_i equals 1.
  - bge/bgeu (101/111): alu_res_i equals 0.
  - funct3 010 and 011: never taken.

  A taken branch gives pc_sel_o=2'b01; otherwise pc_sel_o=2'b00.
- R8: Opcode 0x6F gives pc_sel_o=2'b10 and opcode 0x67 gives pc_sel_o=2'b11. Both give wb_sel_o=2'b11 and reg_we_o=1.
- R9: stall_req_o is 1 exactly when pc_sel_o is not 2'b00.
- R10: While stall_i=1, reg_we_o, gpio_we_o and stall_req_o are 0 and pc_sel_o=2'b00.
- R11: Other opcodes, and 0x73 with any other funct3 or CSR field, give reg_we_o=0, gpio_we_o=0 and pc_sel_o=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 7 | Opcode field of the executing instruction |
| funct3_i | input | 3 | funct3 field |
| funct7_i | input | 7 | funct7 field |
| csr_i | input | 12 | Immediate / CSR address field |
| stall_i | input | 1 | Registered squash flag for this instruction |
| alu_res_i | input | XLEN | ALU result for this instruction |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| alu_op_o | output | 4 | ALU operation code |
| alu_src_o | output | 1 | ALU B operand: 0 register, 1 immediate |
| wb_sel_o | output | 2 | Writeback source: 00 switches, 01 upper immediate, 10 ALU, 11 link PC |
| reg_we_o | output | 1 | Register file write enable |
| gpio_we_o | output | 1 | Display register write enable |
| pc_sel_o | output | 2 | Next PC: 00 sequential, 01 branch, 10 jal, 11 jalr |
| stall_req_o | output | 1 | Squash the next fetched instruction |

## Verification
Every output depends only on the present inputs, so each result is due in the same cycle in which its stimulus is applied. No register lies on any path. The bench drives a new instruction and ALU result at each falling clock edge and samples the outputs 1 ns later, well before the next rising edge, so no sample overlaps a change of stimulus.

// File: rtl/rv_ctrl_pkg.sv
package rv_ctrl_pkg;
  typedef enum logic [3:0] {
    ALU_AND   = 4'b0000, ALU_OR    = 4'b0001, ALU_XOR  = 4'b0010,
    ALU_ADD   = 4'b0011, ALU_SUB   = 4'b0100, ALU_MUL  = 4'b0101,
    ALU_MULH  = 4'b0110, ALU_MULHU = 4'b0111, ALU_SLL  = 4'b1000,
    ALU_SRL   = 4'b1001, ALU_SRA   = 4'b1010, ALU_SLT  = 4'b1100,
    ALU_SLTU  = 4'b1101
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_SWITCH = 2'b00, WB_UPPER = 2'b01, WB_ALU = 2'b10, WB_LINK = 2'b11
  } wb_sel_e;

  typedef enum logic [1:0] {
    PC_SEQ = 2'b00, PC_BRANCH = 2'b01, PC_JAL = 2'b10, PC_JALR = 2'b11
  } pc_sel_e;

  localparam logic [6:0] OPC_REG  = 7'h33;
  localparam logic [6:0] OPC_IMM  = 7'h13;
  localparam logic [6:0] OPC_LUI  = 7'h37;
  localparam logic [6:0] OPC_SYS  = 7'h73;
  localparam logic [6:0] OPC_BR   = 7'h63;
  localparam logic [6:0] OPC_JAL  = 7'h6F;
  localparam logic [6:0] OPC_JALR = 7'h67;
  localparam logic [2:0] F3_CSRRW = 3'b001;
endpackage

// File: rtl/rv_alu_decode.sv
module rv_alu_decode
  import rv_ctrl_pkg::*;
(
  input  logic [6:0] opcode_i,
  input  logic [2:0] funct3_i,
  input  logic [6:0] funct7_i,
  output alu_op_e    alu_op_o,
  output logic       alu_src_o
);
  logic is_reg, mul_grp, alt;

  assign is_reg  = (opcode_i == OPC_REG);
  assign mul_grp = is_reg & funct7_i[0];
  assign alt     = funct7_i[5];

  always_comb begin
    alu_op_o  = ALU_ADD;
    alu_src_o = 1'b0;
    case (opcode_i)
      OPC_REG, OPC_IMM: begin
        alu_src_o = ~is_reg;
        case (funct3_i)
          3'b000:  alu_op_o = mul_grp ? ALU_MUL : ((alt & is_reg) ? ALU_SUB : ALU_ADD);
          3'b001:  alu_op_o = mul_grp ? ALU_MULH : ALU_SLL;
          3'b010:  alu_op_o = ALU_SLT;
          3'b011:  alu_op_o = mul_grp ? ALU_MULHU : ALU_SLTU;
          3'b100:  alu_op_o = ALU_XOR;
          3'b101:  alu_op_o = alt ? ALU_SRA : ALU_SRL;
          3'b110:  alu_op_o = ALU_OR;
          default: alu_op_o = ALU_AND;
        endcase
      end
      OPC_BR: begin
        case (funct3_i)
          3'b000, 3'b001: alu_op_o = ALU_SUB;
          3'b110, 3'b111: alu_op_o = ALU_SLTU;
          default:        alu_op_o = ALU_SLT;
        endcase
      end
      OPC_JALR: alu_src_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/rv_branch_eval.sv
module rv_branch_eval #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      funct3_i,
  input  logic [XLEN-1:0] alu_res_i,
  input  logic            alu_zero_i,
  output logic            taken_o
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  logic res_one, res_nil;
  assign res_one = (alu_res_i == ONE);
  assign res_nil = (alu_res_i == '0);

  always_comb begin
    case (funct3_i)
      3'b000:         taken_o = alu_zero_i;
      3'b001:         taken_o = ~alu_zero_i;
      3'b100, 3'b110: taken_o = res_one;
      3'b101, 3'b111: taken_o = res_nil;
      default:        taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rv_ctrl_unit.sv
module rv_ctrl_unit
  import rv_ctrl_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [11:0] CSR_SW  = 12'hF00,
  parameter logic [11:0] CSR_HEX = 12'hF02
) (
  input  logic [6:0]      opcode_i,
  input  logic [2:0]      funct3_i,
  input  logic [6:0]      funct7_i,
  input  logic [11:0]     csr_i,
  input  logic            stall_i,
  input  logic [XLEN-1:0] alu_res_i,
  input  logic            alu_zero_i,
  output logic [3:0]      alu_op_o,
  output logic            alu_src_o,
  output logic [1:0]      wb_sel_o,
  output logic            reg_we_o,
  output logic            gpio_we_o,
  output logic [1:0]      pc_sel_o,
  output logic            stall_req_o
);
  alu_op_e alu_op;
  wb_sel_e wb_sel;
  pc_sel_e pc_raw, pc_sel;
  logic    br_taken, we_raw, gpio_raw;

  rv_alu_decode i_alu_decode (
    .opcode_i (opcode_i),
    .funct3_i (funct3_i),
    .funct7_i (funct7_i),
    .alu_op_o (alu_op),
    .alu_src_o(alu_src_o)
  );

  rv_branch_eval #(.XLEN(XLEN)) i_branch_eval (
    .funct3_i  (funct3_i),
    .alu_res_i (alu_res_i),
    .alu_zero_i(alu_zero_i),
    .taken_o   (br_taken)
  );

  always_comb begin
    wb_sel   = WB_ALU;
    we_raw   = 1'b0;
    gpio_raw = 1'b0;
    pc_raw   = PC_SEQ;
    case (opcode_i)
      OPC_REG, OPC_IMM: we_raw = 1'b1;
      OPC_LUI: begin
        wb_sel = WB_UPPER;
        we_raw = 1'b1;
      end
      OPC_SYS: begin
        if (funct3_i == F3_CSRRW) begin
          if (csr_i == CSR_HEX) gpio_raw = 1'b1;
          else if (csr_i == CSR_SW) begin
            wb_sel = WB_SWITCH;
            we_raw = 1'b1;
          end
        end
      end
      OPC_BR: if (br_taken) pc_raw = PC_BRANCH;
      OPC_JAL: begin
        wb_sel = WB_LINK;
        we_raw = 1'b1;
        pc_raw = PC_JAL;
      end
      OPC_JALR: begin
        wb_sel = WB_LINK;
        we_raw = 1'b1;
        pc_raw = PC_JALR;
      end
      default: ;
    endcase
  end

  // squashed instruction: no architectural effect
  assign pc_sel      = stall_i ? PC_SEQ : pc_raw;
  assign reg_we_o    = we_raw & ~stall_i;
  assign gpio_we_o   = gpio_raw & ~stall_i;
  assign stall_req_o = (pc_sel != PC_SEQ);
  assign pc_sel_o    = pc_sel;
  assign wb_sel_o    = wb_sel;
  assign alu_op_o    = alu_op;
endmodule

// File: rtl/rv_ctrl_unit_chk.sv
module rv_ctrl_unit_chk #(
  parameter int XLEN = 32
) (
  input logic [6:0]      opcode_i,
  input logic [2:0]      funct3_i,
  input logic            stall_i,
  input logic [XLEN-1:0] alu_res_i,
  input logic [3:0]      alu_op_o,
  input logic [1:0]      wb_sel_o,
  input logic            reg_we_o,
  input logic            gpio_we_o,
  input logic [1:0]      pc_sel_o,
  input logic            stall_req_o
);
  always_comb begin
    a_r10_stall_quiet: assert (!stall_i || (!reg_we_o && !gpio_we_o && pc_sel_o == 2'b00 && !stall_req_o))
      else $error("R10 squashed instruction has side effects");
    a_r4_gpio_no_reg: assert (!gpio_we_o || (!reg_we_o && opcode_i == 7'h73))
      else $error("R4 display write with register write or wrong opcode");
    a_r7_branch_src: assert (pc_sel_o != 2'b01 || opcode_i == 7'h63)
      else $error("R7 branch redirect from non-branch");
    a_r8_link_src: assert (!(reg_we_o && wb_sel_o == 2'b11) || opcode_i == 7'h6F || opcode_i == 7'h67)
      else $error("R8 link writeback from non-jump");
    a_r9_req_jumps: assert (!stall_req_o || opcode_i == 7'h63 || opcode_i == 7'h6F || opcode_i == 7'h67)
      else $error("R9 squash request from non-redirect");
    a_r6_branch_nowr: assert (opcode_i != 7'h63 || (!reg_we_o && alu_op_o != 4'b0011))
      else $error("R6 branch writes or uses add");
    a_r7_lt_taken: assert (stall_i || opcode_i != 7'h63 || funct3_i != 3'b100 || alu_res_i != XLEN'(1) || pc_sel_o == 2'b01)
      else $error("R7 blt with result 1 not taken");
  end
endmodule

bind rv_ctrl_unit rv_ctrl_unit_chk #(.XLEN(XLEN)) i_rv_ctrl_unit_chk (
  .opcode_i   (opcode_i),
  .funct3_i   (funct3_i),
  .stall_i    (stall_i),
  .alu_res_i  (alu_res_i),
  .alu_op_o   (alu_op_o),
  .wb_sel_o   (wb_sel_o),
  .reg_we_o   (reg_we_o),
  .gpio_we_o  (gpio_we_o),
  .pc_sel_o   (pc_sel_o),
  .stall_req_o(stall_req_o)
);

// File: tb/test_rv_ctrl_unit.sv
module test_rv_ctrl_unit;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [6:0]      opcode, funct7;
  logic [2:0]      funct3;
  logic [11:0]     csr;
  logic            stall, zero;
  logic [XLEN-1:0] res;
  logic [3:0]      alu_op_o;
  logic            alu_src_o, reg_we_o, gpio_we_o, stall_req_o;
  logic [1:0]      wb_sel_o, pc_sel_o;

  int checks = 0;
  int errors = 0;

  assign zero = (res == '0);

  rv_ctrl_unit #(.XLEN(XLEN)) i_rv_ctrl_unit (
    .opcode_i(opcode), .funct3_i(funct3), .funct7_i(funct7), .csr_i(csr),
    .stall_i(stall), .alu_res_i(res), .alu_zero_i(zero),
    .alu_op_o(alu_op_o), .alu_src_o(alu_src_o), .wb_sel_o(wb_sel_o),
    .reg_we_o(reg_we_o), .gpio_we_o(gpio_we_o), .pc_sel_o(pc_sel_o),
    .stall_req_o(stall_req_o)
  );

  typedef struct packed {
    logic [3:0] op;
    logic       src;
    logic [1:0] wb;
    logic       we;
    logic       gp;
    logic [1:0] pc;
    logic       sr;
    logic       chk_alu;
  } exp_t;

  function automatic exp_t model(logic [6:0] opc, logic [2:0] f3, logic [6:0] f7,
                                 logic [11:0] c, logic st, logic [XLEN-1:0] r);
    exp_t e;
    logic m, s, tk;
    e = '0;
    e.wb = 2'b10;
    m = (opc == 7'h33) && (f7 == 7'h01);
    s = (f7 == 7'h20);
    if (opc == 7'h33 || opc == 7'h13) begin
      e.chk_alu = 1'b1;
      e.src = (opc == 7'h13);
      e.we = 1'b1;
      case (f3)
        3'b000: e.op = m ? 4'b0101 : ((s && opc == 7'h33) ? 4'b0100 : 4'b0011);
        3'b001: e.op = m ? 4'b0110 : 4'b1000;
        3'b010: e.op = 4'b1100;
        3'b011: e.op = m ? 4'b0111 : 4'b1101;
        3'b100: e.op = 4'b0010;
        3'b101: e.op = s ? 4'b1010 : 4'b1001;
        3'b110: e.op = 4'b0001;
        default: e.op = 4'b0000;
      endcase
    end else if (opc == 7'h37) begin
      e.wb = 2'b01; e.we = 1'b1;
    end else if (opc == 7'h73 && f3 == 3'b001 && c == 12'hF02) begin
      e.gp = 1'b1;
    end else if (opc == 7'h73 && f3 == 3'b001 && c == 12'hF00) begin
      e.wb = 2'b00; e.we = 1'b1;
    end else if (opc == 7'h63) begin
      e.chk_alu = 1'b1;
      e.op = (f3 < 3'd2) ? 4'b0100 : (f3 >= 3'd6) ? 4'b1101 : 4'b1100;
      case (f3)
        3'b000: tk = (r == 0);
        3'b001: tk = (r != 0);
        3'b100, 3'b110: tk = (r == 1);
        3'b101, 3'b111: tk = (r == 0);
        default: tk = 1'b0;
      endcase
      e.pc = tk ? 2'b01 : 2'b00;
    end else if (opc == 7'h6F) begin
      e.wb = 2'b11; e.we = 1'b1; e.pc = 2'b10;
    end else if (opc == 7'h67) begin
      e.wb = 2'b11; e.we = 1'b1; e.pc = 2'b11;
    end
    if (st) begin
      e.we = 1'b0; e.gp = 1'b0; e.pc = 2'b00;
    end
    e.sr = (e.pc != 2'b00);
    return e;
  endfunction

  function automatic string tag_of(logic [6:0] opc, logic [2:0] f3, logic [11:0] c, logic st);
    if (st) return "R10";
    case (opc)
      7'h33: return "R1";
      7'h13: return "R2";
      7'h37: return "R3";
      7'h73: return (f3 == 3'b001 && c == 12'hF02) ? "R4" :
                    (f3 == 3'b001 && c == 12'hF00) ? "R5" : "R11";
      7'h63: return "R7";
      7'h6F, 7'h67: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic cmp(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s opc=%h f3=%b f7=%h csr=%h st=%b res=%h actual=%h expected=%h",
               tag, what, opcode, funct3, funct7, csr, stall, res, act, exp);
    end
  endtask

  task automatic apply(logic [6:0] opc, logic [2:0] f3, logic [6:0] f7,
                       logic [11:0] c, logic st, logic [XLEN-1:0] r);
    exp_t e;
    string t;
    @(negedge clk);
    opcode = opc; funct3 = f3; funct7 = f7; csr = c; stall = st; res = r;
    #1;
    e = model(opc, f3, f7, c, st, r);
    t = tag_of(opc, f3, c, st);
    if (e.chk_alu && !st) begin
      cmp((opc == 7'h63) ? "R6" : t, "alu_op", alu_op_o, e.op);
      cmp((opc == 7'h63) ? "R6" : t, "alu_src", {3'b0, alu_src_o}, {3'b0, e.src});
    end
    cmp(t, "reg_we", {3'b0, reg_we_o}, {3'b0, e.we});
    cmp(t, "gpio_we", {3'b0, gpio_we_o}, {3'b0, e.gp});
    cmp(t, "pc_sel", {2'b0, pc_sel_o}, {2'b0, e.pc});
    cmp("R9", "stall_req", {3'b0, stall_req_o}, {3'b0, e.sr});
    if (e.we) cmp(t, "wb_sel", {2'b0, wb_sel_o}, {2'b0, e.wb});
  endtask

  function automatic logic [6:0] pick_opc(int unsigned k);
    case (k % 9)
      0: return 7'h33;
      1: return 7'h13;
      2: return 7'h37;
      3: return 7'h73;
      4: return 7'h63;
      5: return 7'h6F;
      6: return 7'h67;
      7: return 7'h63;
      default: return 7'($urandom);
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    opcode = '0; funct3 = '0; funct7 = '0; csr = '0; stall = 1'b0; res = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state-like idle input: opcode 0 is unknown (R11)
    apply(7'h00, 3'b000, 7'h00, 12'h000, 1'b0, '0);
    // R1 full register-register map
    for (int f = 0; f < 8; f++) begin
      apply(7'h33, 3'(f), 7'h00, 12'h0, 1'b0, 32'h5);
      apply(7'h33, 3'(f), 7'h20, 12'h0, 1'b0, 32'h5);
      apply(7'h33, 3'(f), 7'h01, 12'h0, 1'b0, 32'h5);
    end
    // R2 immediate map, including srai and addi with imm bit set
    for (int f = 0; f < 8; f++) begin
      apply(7'h13, 3'(f), 7'h00, 12'h0, 1'b0, 32'h0);
      apply(7'h13, 3'(f), 7'h20, 12'h0, 1'b0, 32'h0);
    end
    apply(7'h37, 3'b000, 7'h6D, 12'hDBE, 1'b0, '0);           // R3
    apply(7'h73, 3'b001, 7'h00, 12'hF02, 1'b0, '0);           // R4
    apply(7'h73, 3'b001, 7'h00, 12'hF00, 1'b0, '0);           // R5
    apply(7'h73, 3'b001, 7'h00, 12'hF01, 1'b0, '0);           // R11 unknown CSR
    apply(7'h73, 3'b010, 7'h00, 12'hF02, 1'b0, '0);           // R11 wrong funct3
    // R6 R7 every branch with zero, one and other results
    for (int f = 0; f < 8; f++) begin
      apply(7'h63, 3'(f), 7'h00, 12'h0, 1'b0, 32'h0);
      apply(7'h63, 3'(f), 7'h00, 12'h0, 1'b0, 32'h1);
      apply(7'h63, 3'(f), 7'h00, 12'h0, 1'b0, 32'hFFFF_FFFF);
    end
    apply(7'h6F, 3'b000, 7'h00, 12'h0, 1'b0, '0);             // R8 jal
    apply(7'h67, 3'b000, 7'h00, 12'h0, 1'b0, '0);             // R8 jalr
    // R10 squashed redirects and writes
    apply(7'h6F, 3'b000, 7'h00, 12'h0, 1'b1, '0);
    apply(7'h63, 3'b000, 7'h00, 12'h0, 1'b1, '0);
    apply(7'h73, 3'b001, 7'h00, 12'hF02, 1'b1, '0);
    apply(7'h33, 3'b000, 7'h00, 12'h0, 1'b1, '0);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [6:0] o, f7;
      logic [11:0] c;
      logic [XLEN-1:0] r;
      int unsigned k;
      o = pick_opc($urandom);
      k = $urandom % 3;
      f7 = (k == 0) ? 7'h00 : (k == 1) ? 7'h20 : 7'h01;
      if (o == 7'h13 && f7 == 7'h01) f7 = 7'h00;
      k = $urandom % 3;
      c = (k == 0) ? 12'hF00 : (k == 1) ? 12'hF02 : 12'($urandom);
      k = $urandom % 3;
      r = (k == 0) ? '0 : (k == 1) ? XLEN'(1) : XLEN'($urandom);
      apply(o, 3'($urandom), f7, c, ($urandom % 8) == 0, r);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule